// File: doc/BRIEF.md
# Generalized OR-Combine Execute Unit

This unit executes the generalized OR-combine bit-manipulation operation for a 64-bit core. It takes a 32-bit instruction word with two source values. It recognises four variants: a register form, an immediate form, and a 32-bit word version of each. It computes the result and presents it one clock later together with a valid strobe, or with an illegal flag when the instruction is not one it can execute.

The datapath is a chain of six stages. The stage at position k pairs each bit with the bit whose index differs only in bit k, that is, at distance 2^k. When bit k of the control amount is set, the stage ORs every bit with its partner. Disabled stages pass their input through. Because the stages accumulate instead of permuting, an amount of 7 turns every nonzero byte into 0xFF.

The word forms use only the low 32 bits of the source, zero-extended, and run the five lowest stages. They copy bit 31 of the result into the upper half.

Top module: `gorc_unit`

## Requirements
- R1: While reset is held, and on the first clock after it, `out_valid_q` and `illegal_q` are low and `res_q` is zero.
- R2: Register form: instr[31:25]=0010100, instr[14:12]=101, instr[6:0]=0110011. The amount is `src_b[5:0]`, and `src_b[63:6]` has no effect.
- R3: Stage k (k = 0..5, distances 1, 2, 4, 8, 16, 32, applied in increasing order) is enabled by amount bit k. An enabled stage sets each bit i to x[i] OR x[i XOR 2^k] of its input. A disabled stage leaves its input unchanged.
- R4: With amount 7, each result byte is 0xFF when the matching source byte is nonzero, and 0x00 otherwise.
- R5: Amount 0 returns the source unchanged (the sign-extended low word for word forms). A zero source gives a zero result for any amount.
- R6: Immediate form: instr[31:27]=00101, instr[14:12]=101, instr[6:0]=0010011, with a 7-bit amount in instr[26:20]. An amount of 64 or more (instr[26]=1) is illegal.
- R7: Word register form: the same fields as R2 with instr[6:0]=0111011. The source is `src_a[31:0]` zero-extended and the amount is `src_b[4:0]`. Only stages 0..4 run, and result bits 63:32 copy bit 31.
- R8: Word immediate form: instr[31:26]=001010, instr[14:12]=101, instr[6:0]=0011011, with a 6-bit amount in instr[25:20]. An amount of 32 or more (instr[25]=1) is illegal. Otherwise it behaves as R7.
- R9: A valid instruction that is none of the four legal variants gives `illegal_q`=1, `out_valid_q`=0 and `res_q`=0 on the next cycle.
- R10: Outputs are registered with one cycle of latency. In a cycle after one without `in_valid`, both flags are low and `res_q` holds its previous value.
- R11: Every bit that is set in the (zero-extended) source is also set in the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An instruction is presented this cycle |
| instr | input | 32 | Instruction word |
| src_a | input | 64 | Source value to combine |
| src_b | input | 64 | Second operand; supplies the amount for register forms |
| res_q | output | 64 | Registered result |
| illegal_q | output | 1 | Registered illegal-instruction flag |
| out_valid_q | output | 1 | Registered result-valid strobe |

## Verification
The assertions assume that `in_valid`, `instr`, `src_a` and `src_b` are stable around each rising edge. They also assume that reset is released away from an edge. The bench changes every input only on the falling clock edge and samples the outputs on the next falling edge. The property that compares a zero-amount result with the source relies on the source being sampled in the same cycle as the valid instruction. The bench always presents source and instruction together for exactly one cycle, and follows each with an idle cycle when it tests that outputs hold.

// File: rtl/gorc_pkg.sv
package gorc_pkg;

  localparam int GORC_XLEN = 64;
  localparam int GORC_WLEN = 32;

  localparam logic [6:0] OPC_REG   = 7'b0110011;
  localparam logic [6:0] OPC_REGW  = 7'b0111011;
  localparam logic [6:0] OPC_IMM   = 7'b0010011;
  localparam logic [6:0] OPC_IMMW  = 7'b0011011;
  localparam logic [2:0] F3_ORC    = 3'b101;
  localparam logic [6:0] F7_ORC    = 7'b0010100;
  localparam logic [4:0] F5_ORC    = 5'b00101;
  localparam logic [5:0] F6_ORC    = 6'b001010;

  typedef enum logic [2:0] {
    ORC_NONE = 3'd0,
    ORC_REG  = 3'd1,
    ORC_IMM  = 3'd2,
    ORC_REGW = 3'd3,
    ORC_IMMW = 3'd4
  } orc_kind_e;

endpackage

// File: rtl/gorc_decode.sv
module gorc_decode
  import gorc_pkg::*;
#(
  parameter int XLEN = GORC_XLEN,
  parameter int WLEN = GORC_WLEN,
  localparam int LX = $clog2(XLEN),
  localparam int LW = $clog2(WLEN)
) (
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] src_a,
  input  logic [XLEN-1:0] src_b,
  output orc_kind_e       kind,
  output logic            legal,
  output logic            is_word,
  output logic [LX-1:0]   amount,
  output logic [XLEN-1:0] src_ext
);

  logic [6:0] opc;
  logic       f3_hit;
  logic       reg_hit, regw_hit, imm_cand, immw_cand;
  logic [6:0] imm_amt;
  logic [5:0] immw_amt;
  logic       imm_in_range, immw_in_range;

  assign opc      = instr[6:0];
  assign f3_hit   = (instr[14:12] == F3_ORC);
  assign imm_amt  = instr[26:20];
  assign immw_amt = instr[25:20];

  assign reg_hit   = (opc == OPC_REG)  && (instr[31:25] == F7_ORC) && f3_hit;
  assign regw_hit  = (opc == OPC_REGW) && (instr[31:25] == F7_ORC) && f3_hit;
  assign imm_cand  = (opc == OPC_IMM)  && (instr[31:27] == F5_ORC) && f3_hit;
  assign immw_cand = (opc == OPC_IMMW) && (instr[31:26] == F6_ORC) && f3_hit;

  assign imm_in_range  = (32'(imm_amt)  < XLEN);
  assign immw_in_range = (32'(immw_amt) < WLEN);

  always_comb begin
    kind = ORC_NONE;
    if (reg_hit)                         kind = ORC_REG;
    else if (regw_hit)                   kind = ORC_REGW;
    else if (imm_cand && imm_in_range)   kind = ORC_IMM;
    else if (immw_cand && immw_in_range) kind = ORC_IMMW;
  end

  assign legal   = (kind != ORC_NONE);
  assign is_word = (kind == ORC_REGW) || (kind == ORC_IMMW);

  always_comb begin
    unique case (kind)
      ORC_REG:  amount = src_b[LX-1:0];
      ORC_REGW: amount = LX'(src_b[LW-1:0]);
      ORC_IMM:  amount = imm_amt[LX-1:0];
      ORC_IMMW: amount = LX'(immw_amt[LW-1:0]);
      default:  amount = '0;
    endcase
  end

  assign src_ext = is_word ? XLEN'(src_a[WLEN-1:0]) : src_a;

endmodule

// File: rtl/gorc_network.sv
module gorc_network #(
  parameter int XLEN = 64,
  localparam int NSTAGE = $clog2(XLEN)
) (
  input  logic [XLEN-1:0]   din,
  input  logic [NSTAGE-1:0] stage_en,
  output logic [XLEN-1:0]   dout
);

  function automatic logic [XLEN-1:0] stage_mask(input int k);
    logic [XLEN-1:0] m;
    for (int i = 0; i < XLEN; i++) m[i] = ((i >> k) & 1) == 0;
    return m;
  endfunction

  function automatic logic [XLEN-1:0] pair_swap(input logic [XLEN-1:0] x, input int k);
    logic [XLEN-1:0] m;
    m = stage_mask(k);
    return ((x & m) << (1 << k)) | ((x & ~m) >> (1 << k));
  endfunction

  logic [NSTAGE:0][XLEN-1:0] chain;

  assign chain[0] = din;

  for (genvar k = 0; k < NSTAGE; k++) begin : g_stage
    logic [XLEN-1:0] combined;
    assign combined     = chain[k] | pair_swap(chain[k], k);
    assign chain[k + 1] = stage_en[k] ? combined : chain[k];
  end

  assign dout = chain[NSTAGE];

endmodule

// File: rtl/gorc_out_reg.sv
module gorc_out_reg #(
  parameter int XLEN = 64,
  parameter int WLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic            legal,
  input  logic            is_word,
  input  logic [XLEN-1:0] net_out,
  output logic [XLEN-1:0] res_q,
  output logic            illegal_q,
  output logic            out_valid_q
);

  function automatic logic [XLEN-1:0] word_sext(input logic [XLEN-1:0] x);
    return {{(XLEN - WLEN){x[WLEN-1]}}, x[WLEN-1:0]};
  endfunction

  logic [XLEN-1:0] final_res;
  assign final_res = is_word ? word_sext(net_out) : net_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q       <= '0;
      illegal_q   <= 1'b0;
      out_valid_q <= 1'b0;
    end else begin
      out_valid_q <= in_valid && legal;
      illegal_q   <= in_valid && !legal;
      if (in_valid) res_q <= legal ? final_res : '0;
    end
  end

endmodule

// File: rtl/gorc_unit.sv
module gorc_unit
  import gorc_pkg::*;
#(
  parameter int XLEN = GORC_XLEN,
  parameter int WLEN = GORC_WLEN,
  localparam int LX = $clog2(XLEN),
  localparam int LW = $clog2(WLEN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] src_a,
  input  logic [XLEN-1:0] src_b,
  output logic [XLEN-1:0] res_q,
  output logic            illegal_q,
  output logic            out_valid_q
);

  orc_kind_e       dec_kind;
  logic            dec_legal;
  logic            dec_word;
  logic [LX-1:0]   dec_amount;
  logic [XLEN-1:0] dec_src;
  logic [LX-1:0]   stage_en;
  logic [LX-1:0]   word_stage_mask;
  logic [XLEN-1:0] net_out;

  gorc_decode #(.XLEN(XLEN), .WLEN(WLEN)) u_dec (
    .instr   (instr),
    .src_a   (src_a),
    .src_b   (src_b),
    .kind    (dec_kind),
    .legal   (dec_legal),
    .is_word (dec_word),
    .amount  (dec_amount),
    .src_ext (dec_src)
  );

  assign word_stage_mask = LX'((1 << LW) - 1);
  assign stage_en = dec_word ? (dec_amount & word_stage_mask) : dec_amount;

  gorc_network #(.XLEN(XLEN)) u_net (
    .din      (dec_src),
    .stage_en (stage_en),
    .dout     (net_out)
  );

  gorc_out_reg #(.XLEN(XLEN), .WLEN(WLEN)) u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .legal       (dec_legal),
    .is_word     (dec_word),
    .net_out     (net_out),
    .res_q       (res_q),
    .illegal_q   (illegal_q),
    .out_valid_q (out_valid_q)
  );

endmodule

// File: rtl/gorc_unit_chk.sv
module gorc_unit_chk #(
  parameter int XLEN = 64,
  parameter int WLEN = 32,
  parameter int LX = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            dec_legal,
  input logic            dec_word,
  input logic [LX-1:0]   dec_amount,
  input logic [XLEN-1:0] dec_src,
  input logic [XLEN-1:0] res_q,
  input logic            illegal_q,
  input logic            out_valid_q
);

  assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(illegal_q && out_valid_q));

  assert_legal_gives_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dec_legal) |=> (out_valid_q && !illegal_q));

  assert_illegal_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !dec_legal) |=> (illegal_q && res_q == '0));

  assert_idle_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid_q && !illegal_q && $stable(res_q)));

  assert_zero_amount_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dec_legal && !dec_word && dec_amount == '0) |=> (res_q == $past(dec_src)));

  assert_zero_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dec_legal && dec_src == '0) |=> (res_q == '0));

  assert_word_sext_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dec_legal && dec_word) |=> (res_q[XLEN-1:WLEN] == {(XLEN-WLEN){res_q[WLEN-1]}}));

  assert_superset_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dec_legal) |=> ((res_q & $past(dec_src)) == $past(dec_src)));

endmodule

bind gorc_unit gorc_unit_chk #(.XLEN(XLEN), .WLEN(WLEN), .LX(LX)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .dec_legal   (dec_legal),
  .dec_word    (dec_word),
  .dec_amount  (dec_amount),
  .dec_src     (dec_src),
  .res_q       (res_q),
  .illegal_q   (illegal_q),
  .out_valid_q (out_valid_q)
);

// File: tb/gorc_unit_tb.sv
module gorc_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [63:0] src_a = '0;
  logic [63:0] src_b = '0;
  logic [63:0] res_q;
  logic        illegal_q;
  logic        out_valid_q;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  gorc_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
    .src_a(src_a), .src_b(src_b), .res_q(res_q),
    .illegal_q(illegal_q), .out_valid_q(out_valid_q)
  );

  // kinds: 0 register, 1 word register, 2 immediate, 3 word immediate, 4 raw word in b
  function automatic logic [31:0] encode(int kind, logic [63:0] b);
    case (kind)
      0: return {7'b0010100, 5'd2, 5'd1, 3'b101, 5'd3, 7'b0110011};
      1: return {7'b0010100, 5'd2, 5'd1, 3'b101, 5'd3, 7'b0111011};
      2: return {5'b00101, b[6:0], 5'd1, 3'b101, 5'd3, 7'b0010011};
      3: return {6'b001010, b[5:0], 5'd1, 3'b101, 5'd3, 7'b0011011};
      default: return b[31:0];
    endcase
  endfunction

  // bitwise model: partner of bit i at distance s is bit i^s
  function automatic logic [63:0] model(int kind, logic [63:0] a, logic [63:0] b);
    logic [63:0] x, y;
    int amt, n;
    bit word;
    word = (kind == 1) || (kind == 3);
    n = word ? 32 : 64;
    amt = (kind == 1) ? int'(b[4:0]) : int'(b[5:0]);
    x = word ? {32'b0, a[31:0]} : a;
    for (int s = 1; s < n; s = s * 2) begin
      if ((amt & s) != 0) begin
        y = x;
        for (int i = 0; i < n; i++) x[i] = y[i] | y[i ^ s];
      end
    end
    return word ? {{32{x[31]}}, x[31:0]} : x;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_op(int kind, logic [63:0] a, logic [63:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    src_a    = a;
    src_b    = b;
    instr    = encode(kind, b);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  localparam int NV = 14;
  localparam int TV_KIND [NV] = '{0, 0, 0, 0, 0, 0, 2, 2, 1, 1, 3, 3, 2, 0};
  localparam logic [63:0] TV_A [NV] = '{
    64'h1, 64'h1, 64'h1, 64'h1,
    64'h0012_0000_0300_0040, 64'h0012_0000_0300_0040,
    64'h8000_0000_0000_0000, 64'h0000_0000_DEAD_BEEF,
    64'hFFFF_FFFF_0000_0001, 64'h0000_0000_8000_0000,
    64'h0000_0000_0000_0100, 64'h1234_5678_0001_0000,
    64'h0, 64'h0
  };
  localparam logic [63:0] TV_B [NV] = '{
    64'd1, 64'd3, 64'd32, 64'd24, 64'd7, 64'hFFFF_FFFF_FFFF_FFC7,
    64'd63, 64'd0, 64'd0, 64'h30, 64'd31, 64'd8, 64'd63, 64'd7
  };
  localparam logic [63:0] TV_EXP [NV] = '{
    64'h3, 64'hF, 64'h0000_0001_0000_0001, 64'h0101_0101,
    64'h00FF_0000_FF00_00FF, 64'h00FF_0000_FF00_00FF,
    64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_DEAD_BEEF,
    64'h1, 64'hFFFF_FFFF_8000_8000,
    64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0101_0000,
    64'h0, 64'h0
  };
  localparam string TV_REQ [NV] = '{
    "R3", "R3", "R3", "R3", "R4", "R2", "R6", "R5",
    "R7", "R7", "R8", "R8", "R5", "R5"
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [63:0] held;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", {63'b0, out_valid_q}, 64'h0);
    chk("R1 result in reset", res_q, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 illegal after reset", {63'b0, illegal_q}, 64'h0);
    chk("R1 valid after reset", {63'b0, out_valid_q}, 64'h0);

    for (int v = 0; v < NV; v++) begin
      run_op(TV_KIND[v], TV_A[v], TV_B[v]);
      chk(TV_REQ[v], res_q, TV_EXP[v]);
      chk("R10 valid strobe", {62'b0, out_valid_q, illegal_q}, 64'h2);
    end

    // R10: idle cycle keeps result and drops flags
    held = res_q;
    run_op(0, 64'hFF, 64'd1);
    held = res_q;
    @(negedge clk);
    chk("R10 idle hold", res_q, held);
    chk("R10 idle flags", {62'b0, out_valid_q, illegal_q}, 64'h0);

    // R6: immediate amount 64 illegal
    run_op(2, 64'h1234, 64'd64);
    chk("R6 illegal flag", {62'b0, out_valid_q, illegal_q}, 64'h1);
    chk("R6 illegal result", res_q, 64'h0);

    // R8: word immediate amount 32 illegal
    run_op(3, 64'h1234, 64'd32);
    chk("R8 illegal flag", {62'b0, out_valid_q, illegal_q}, 64'h1);

    // R9: foreign instruction (plain add-immediate) is illegal
    run_op(4, 64'h5, 64'h0000_0013);
    chk("R9 illegal flag", {62'b0, out_valid_q, illegal_q}, 64'h1);
    chk("R9 zero result", res_q, 64'h0);
    // R9: wrong funct3 on register form
    run_op(4, 64'h5, {32'b0, 7'b0010100, 5'd2, 5'd1, 3'b001, 5'd3, 7'b0110011});
    chk("R9 bad funct3", {62'b0, out_valid_q, illegal_q}, 64'h1);

    // random sweep against the bitwise model (R3, R7, R11)
    for (int r = 0; r < 400; r++) begin
      int kind;
      logic [63:0] a, b;
      kind = r % 4;
      a = {$urandom, $urandom};
      if (r % 3 == 0) a = a & {$urandom, $urandom} & {$urandom, $urandom};
      b = {$urandom, $urandom};
      if (kind == 2) b = 64'($urandom_range(0, 63));
      if (kind == 3) b = 64'($urandom_range(0, 31));
      run_op(kind, a, b);
      chk("R3 random", res_q, model(kind, a, b));
      if (kind == 0 || kind == 2)
        chk("R11 superset", res_q & a, a);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule